// File: doc/BRIEF.md
# Timer Tick Prescaler and Source Selector

This block sits beside four timer counters and tells each one when to count. Everything runs on one system clock. The outputs are single-bit count enables that are sampled on that clock. A tick that is held high makes a counter advance on every cycle. A tick that pulses once every N cycles makes it advance at the system rate divided by N. The counters themselves live elsewhere.

Software programs the choice through an 8-bit control register, which it can write and read back. Timers 0 and 1 share a prescaled source. That source is the system clock divided by 12, 4 or 48, or an asynchronous external clock. The external clock is first synchronised and then divided by eight. Each of these two timers can bypass the prescaler and count at the full system rate. When a timer is in counter mode, its count comes from outside and its tick is held low.

Timers 2 and 3 each choose between the full system rate and their own alternate enable input. A low-half select sets the source for the whole 16-bit timer. When the timer is split into two 8-bit halves, a second select sets the high half on its own. Every tick output is registered, so an output reflects its inputs and the control register one cycle later.

Top module: `tmr_tick_gen`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, and a written byte reads back unchanged on `reg_rdata` from the cycle after the write.
- R2: Control bit fields: bit 7 is the timer 3 high-half select and bit 6 the timer 3 low select. Bit 5 is the timer 2 high-half select and bit 4 the timer 2 low select. Bit 3 is the timer 1 select, bit 2 the timer 0 select, and bits 1:0 the prescale code.
- R3: With prescale code 00 and a timer 0/1 select of 0, that timer's tick is a one-cycle pulse every 12 system cycles.
- R4: With prescale code 01 the prescaled tick repeats every 4 cycles.
- R5: With prescale code 10 the prescaled tick repeats every 48 cycles.
- R6: With prescale code 11 the prescaled tick is a one-cycle pulse on every 8th rising edge of `ext_clk`, after that edge is synchronised to the system clock.
- R7: A timer 0/1 select of 1 in timer mode holds that timer's tick high on every cycle.
- R8: A timer 0/1 in counter mode (`tN_cnt_mode` = 1) has its tick held low, whatever its select bit and the prescale code are.
- R9: For timers 2 and 3, a low select of 1 holds the low tick high. A low select of 0 makes the low tick copy the timer's alternate enable input one cycle later.
- R10: With split mode off, a timer 2/3 high tick equals its low tick on every cycle, and the high select has no effect.
- R11: With split mode on, a high select of 1 holds the high tick high. A high select of 0 makes the high tick copy the alternate enable input, whatever the low select is.
- R12: The ÷12, ÷4 and ÷48 counters run all the time. After a change of prescale code, the first tick at the new rate arrives within the new divisor plus one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external clock for the ÷8 prescale source |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| t0_cnt_mode | input | 1 | Timer 0 counts external events (tick held low) |
| t1_cnt_mode | input | 1 | Timer 1 counts external events (tick held low) |
| t2_split | input | 1 | Timer 2 runs as two 8-bit halves |
| t3_split | input | 1 | Timer 3 runs as two 8-bit halves |
| t2_alt_en | input | 1 | Timer 2 alternate clock enable |
| t3_alt_en | input | 1 | Timer 3 alternate clock enable |
| t0_tick | output | 1 | Timer 0 count enable |
| t1_tick | output | 1 | Timer 1 count enable |
| t2_lo_tick | output | 1 | Timer 2 low half (or whole timer) count enable |
| t2_hi_tick | output | 1 | Timer 2 high half count enable |
| t3_lo_tick | output | 1 | Timer 3 low half (or whole timer) count enable |
| t3_hi_tick | output | 1 | Timer 3 high half count enable |

## Verification
The prescaler is tried with all four codes, and the bench measures the spacing between consecutive ticks. The spacing is 12, 4 or 48 cycles, or 80 cycles for an external clock with a period of 10 cycles. So a swapped code or a wrong terminal count shows up as a wrong interval. A prescale change from ÷48 to ÷4 is timed, which separates free-running counters from ones that restart. For timers 2 and 3, the high-half and low-half selects are set to opposite values while the alternate enable is held at both levels, first with split mode off and then on. This shows whether the high select is honoured or ignored. Counter mode is combined with a system-rate select to show that forcing the tick low takes priority.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

  typedef enum logic [1:0] {
    PS_DIV12 = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV48 = 2'b10,
    PS_EXT8  = 2'b11
  } presc_e;

  typedef struct packed {
    logic   t3_hi_sys;
    logic   t3_lo_sys;
    logic   t2_hi_sys;
    logic   t2_lo_sys;
    logic   t1_sys;
    logic   t0_sys;
    presc_e psel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl_q
);

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_t'(wr_data);
  end

  // R1
  ctrl_reset_chk: assert property (@(posedge clk) rst |=> (ctrl_q == '0));

  // R1
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q == $past(wr_data)));

endmodule

// File: rtl/tmr_div.sv
module tmr_div #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic pulse
);

  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign pulse = (cnt == LAST);

  // R12
  div_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

  // R3
  div_single_chk: assert property (@(posedge clk) disable iff (rst) pulse |=> !pulse);

endmodule

// File: rtl/tmr_ext_div.sv
module tmr_ext_div #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EXT_DIV     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  output logic pulse
);

  localparam int unsigned SW = SYNC_STAGES + 1;
  localparam int unsigned CW = (EXT_DIV > 2) ? $clog2(EXT_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(EXT_DIV - 1);

  logic [SW-1:0] sync_q;
  logic          rise;
  logic [CW-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SW-2:0], ext_clk};
  end

  assign rise = sync_q[SW-2] && !sync_q[SW-1];

  always_ff @(posedge clk) begin
    if (rst) edge_cnt <= '0;
    else if (rise) begin
      if (edge_cnt == LAST) edge_cnt <= '0;
      else                  edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assign pulse = rise && (edge_cnt == LAST);

  // R6
  ext_single_chk: assert property (@(posedge clk) disable iff (rst) pulse |=> !pulse);

  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> (edge_cnt == $past(edge_cnt)));

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_tick_pkg::*;
#(
  parameter int unsigned DIV_A       = 12,
  parameter int unsigned DIV_B       = 4,
  parameter int unsigned DIV_C       = 48,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_clk,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       t0_cnt_mode,
  input  logic       t1_cnt_mode,
  input  logic       t2_split,
  input  logic       t3_split,
  input  logic       t2_alt_en,
  input  logic       t3_alt_en,
  output logic       t0_tick,
  output logic       t1_tick,
  output logic       t2_lo_tick,
  output logic       t2_hi_tick,
  output logic       t3_lo_tick,
  output logic       t3_hi_tick
);

  localparam int unsigned NUM_DIV = 3;
  localparam int unsigned DIV_TBL [NUM_DIV] = '{DIV_A, DIV_B, DIV_C};
  localparam int unsigned NUM_PT  = 2;  // prescaled timers
  localparam int unsigned NUM_ST  = 2;  // splittable timers

  ctrl_t ctrl;

  tmr_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_we),
    .wr_data (reg_wdata),
    .ctrl_q  (ctrl)
  );

  assign reg_rdata = ctrl;

  logic [NUM_DIV-1:0] div_pulse;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    tmr_div #(.DIV(DIV_TBL[g])) u_div (
      .clk   (clk),
      .rst   (rst),
      .pulse (div_pulse[g])
    );
  end

  logic ext_pulse;

  tmr_ext_div #(.SYNC_STAGES(SYNC_STAGES), .EXT_DIV(EXT_DIV)) u_ext (
    .clk     (clk),
    .rst     (rst),
    .ext_clk (ext_clk),
    .pulse   (ext_pulse)
  );

  logic presc_tick;

  always_comb begin
    case (ctrl.psel)
      PS_DIV12: presc_tick = div_pulse[0];
      PS_DIV4:  presc_tick = div_pulse[1];
      PS_DIV48: presc_tick = div_pulse[2];
      default:  presc_tick = ext_pulse;
    endcase
  end

  // Timers 0 and 1: prescaled or system rate, gated by counter mode
  logic [NUM_PT-1:0] pt_cnt_mode, pt_sys, pt_d, pt_q;
  assign pt_cnt_mode = {t1_cnt_mode, t0_cnt_mode};
  assign pt_sys      = {ctrl.t1_sys, ctrl.t0_sys};

  for (genvar g = 0; g < NUM_PT; g++) begin : g_pt
    assign pt_d[g] = !pt_cnt_mode[g] && (pt_sys[g] || presc_tick);
  end

  // Timers 2 and 3: system rate or alternate enable, per half
  logic [NUM_ST-1:0] st_split, st_alt, st_lo_sys, st_hi_sys;
  logic [NUM_ST-1:0] lo_d, hi_d, lo_q, hi_q;
  assign st_split  = {t3_split, t2_split};
  assign st_alt    = {t3_alt_en, t2_alt_en};
  assign st_lo_sys = {ctrl.t3_lo_sys, ctrl.t2_lo_sys};
  assign st_hi_sys = {ctrl.t3_hi_sys, ctrl.t2_hi_sys};

  for (genvar g = 0; g < NUM_ST; g++) begin : g_st
    assign lo_d[g] = st_lo_sys[g] || st_alt[g];
    assign hi_d[g] = st_split[g] ? (st_hi_sys[g] || st_alt[g]) : lo_d[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pt_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      pt_q <= pt_d;
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign t0_tick    = pt_q[0];
  assign t1_tick    = pt_q[1];
  assign t2_lo_tick = lo_q[0];
  assign t3_lo_tick = lo_q[1];
  assign t2_hi_tick = hi_q[0];
  assign t3_hi_tick = hi_q[1];

  // R8
  t0_cnt_low_chk: assert property (@(posedge clk) disable iff (rst) t0_cnt_mode |=> !t0_tick);

  // R8
  t1_cnt_low_chk: assert property (@(posedge clk) disable iff (rst) t1_cnt_mode |=> !t1_tick);

  // R7
  t0_sys_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.t0_sys && !t0_cnt_mode) |=> t0_tick);

  // R10
  t2_unsplit_chk: assert property (@(posedge clk) disable iff (rst)
    !t2_split |=> (t2_hi_tick == t2_lo_tick));

  // R10
  t3_unsplit_chk: assert property (@(posedge clk) disable iff (rst)
    !t3_split |=> (t3_hi_tick == t3_lo_tick));

  // R11
  t2_split_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (t2_split && ctrl.t2_hi_sys) |=> t2_hi_tick);

  // R9
  t3_lo_alt_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.t3_lo_sys |=> (t3_lo_tick == $past(t3_alt_en)));

endmodule

// File: tb/tmr_tick_gen_test.sv
`timescale 1ns/1ps
module tmr_tick_gen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_clk = 1'b0;
  logic ext_run = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic t0_cnt_mode = 1'b0, t1_cnt_mode = 1'b0;
  logic t2_split = 1'b0, t3_split = 1'b0;
  logic t2_alt_en = 1'b0, t3_alt_en = 1'b0;
  logic t0_tick, t1_tick, t2_lo_tick, t2_hi_tick, t3_lo_tick, t3_hi_tick;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_tick_gen uut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .t0_cnt_mode(t0_cnt_mode), .t1_cnt_mode(t1_cnt_mode),
    .t2_split(t2_split), .t3_split(t3_split),
    .t2_alt_en(t2_alt_en), .t3_alt_en(t3_alt_en),
    .t0_tick(t0_tick), .t1_tick(t1_tick),
    .t2_lo_tick(t2_lo_tick), .t2_hi_tick(t2_hi_tick),
    .t3_lo_tick(t3_lo_tick), .t3_hi_tick(t3_hi_tick)
  );

  wire [5:0] ticks = {t3_hi_tick, t3_lo_tick, t2_hi_tick, t2_lo_tick, t1_tick, t0_tick};

  // external clock: period of 10 system cycles when running
  initial forever begin
    @(negedge clk);
    if (ext_run) begin
      repeat (4) @(negedge clk);
      ext_clk = ~ext_clk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic gap_of(input int idx, output int gap);
    int n = 0;
    while (!ticks[idx] && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    gap = 1;
    while (!ticks[idx] && gap < 500) begin @(negedge clk); gap++; end
  endtask

  // counts cycles in a window where a tick output differs from the expected level
  task automatic hold_level(input int idx, input bit lvl, input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ticks[idx] !== lvl) bad++;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    check(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
    check(ticks[5:2] == 4'b0, "R9 reset alt-sourced ticks low", ticks[5:2], 0);
  endtask

  task automatic t_regio;
    wr(8'hA5);
    check(reg_rdata == 8'hA5, "R1 readback A5", reg_rdata, 8'hA5);
    wr(8'h5A);
    check(reg_rdata == 8'h5A, "R1 readback 5A", reg_rdata, 8'h5A);
  endtask

  task automatic t_presc;
    int g;
    wr(8'h00);  // prescale 00, t0/t1 selects 0 (R2 bits 1:0, 2, 3)
    cycles(2);
    gap_of(0, g); check(g == 12, "R3 t0 div12 gap", g, 12);
    gap_of(1, g); check(g == 12, "R3 t1 div12 gap", g, 12);
    wr(8'h01);
    cycles(2);
    gap_of(0, g); check(g == 4, "R4 div4 gap", g, 4);
    wr(8'h02);
    cycles(2);
    gap_of(0, g); check(g == 48, "R5 div48 gap", g, 48);
  endtask

  task automatic t_ext;
    int g;
    ext_run = 1'b1;
    wr(8'h03);
    cycles(5);
    gap_of(0, g);
    gap_of(0, g); check(g == 80, "R6 ext div8 gap", g, 80);
    ext_run = 1'b0;
  endtask

  task automatic t_sys_sel;
    int bad;
    wr(8'h06);  // t0 system rate (bit 2), prescale 10
    cycles(1);
    hold_level(0, 1'b1, 60, bad); check(bad == 0, "R7 t0 held high", bad, 0);
    wr(8'h0A);  // t1 system rate (bit 3)
    cycles(1);
    hold_level(1, 1'b1, 60, bad); check(bad == 0, "R7 t1 held high", bad, 0);
  endtask

  task automatic t_cnt_mode;
    int bad;
    wr(8'h0D);  // both selects 1, prescale 01
    t0_cnt_mode = 1'b1;
    t1_cnt_mode = 1'b1;
    cycles(1);
    hold_level(0, 1'b0, 20, bad); check(bad == 0, "R8 t0 low in counter mode", bad, 0);
    hold_level(1, 1'b0, 20, bad); check(bad == 0, "R8 t1 low in counter mode", bad, 0);
    wr(8'h01);
    hold_level(0, 1'b0, 20, bad); check(bad == 0, "R8 t0 low with prescaler", bad, 0);
    t0_cnt_mode = 1'b0;
    t1_cnt_mode = 1'b0;
  endtask

  task automatic t_alt_lo;
    int bad;
    wr(8'h50);  // t2 lo sys (bit 4), t3 lo sys (bit 6)
    cycles(1);
    hold_level(2, 1'b1, 10, bad); check(bad == 0, "R9 t2 lo sys high", bad, 0);
    hold_level(4, 1'b1, 10, bad); check(bad == 0, "R9 t3 lo sys high", bad, 0);
    wr(8'h00);
    cycles(1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      t2_alt_en = (i % 3) == 0;
      t3_alt_en = (i % 2) == 0;
      @(negedge clk);
      check(t2_lo_tick == t2_alt_en, "R9 t2 lo follows alt", t2_lo_tick, t2_alt_en);
      check(t3_lo_tick == t3_alt_en, "R9 t3 lo follows alt", t3_lo_tick, t3_alt_en);
    end
    t2_alt_en = 1'b0;
    t3_alt_en = 1'b0;
  endtask

  task automatic t_split_off;
    int bad;
    t2_split = 1'b0;
    t3_split = 1'b0;
    wr(8'hA0);  // hi selects 1, lo selects 0
    cycles(1);
    hold_level(3, 1'b0, 10, bad); check(bad == 0, "R10 t2 hi ignores select", bad, 0);
    hold_level(5, 1'b0, 10, bad); check(bad == 0, "R10 t3 hi ignores select", bad, 0);
    t2_alt_en = 1'b1;
    cycles(2);
    check(t2_hi_tick && t2_lo_tick, "R10 t2 hi tracks lo", t2_hi_tick, 1);
    wr(8'h50);  // lo sys, hi 0
    t2_alt_en = 1'b0;
    cycles(2);
    check(t2_hi_tick == 1'b1, "R10 t2 hi follows lo sys", t2_hi_tick, 1);
  endtask

  task automatic t_split_on;
    int bad;
    t2_split = 1'b1;
    t3_split = 1'b1;
    wr(8'hA0);
    cycles(1);
    hold_level(3, 1'b1, 10, bad); check(bad == 0, "R11 t2 hi sys high", bad, 0);
    hold_level(5, 1'b1, 10, bad); check(bad == 0, "R11 t3 hi sys high", bad, 0);
    hold_level(2, 1'b0, 5, bad);  check(bad == 0, "R11 t2 lo independent", bad, 0);
    wr(8'h50);  // lo sys, hi select 0
    cycles(1);
    hold_level(3, 1'b0, 10, bad); check(bad == 0, "R11 t2 hi alt low", bad, 0);
    t3_alt_en = 1'b1;
    cycles(2);
    check(t3_hi_tick == 1'b1, "R11 t3 hi follows alt", t3_hi_tick, 1);
    t3_alt_en = 1'b0;
    t2_split = 1'b0;
    t3_split = 1'b0;
  endtask

  task automatic t_switch;
    int n;
    wr(8'h02);
    cycles(17);
    wr(8'h01);
    n = 0;
    while (!t0_tick && n < 60) begin @(negedge clk); n++; end
    check(n <= 5, "R12 tick soon after switch", n, 5);
  endtask

  initial begin
    t_reset();
    t_regio();
    t_presc();
    t_ext();
    t_sys_sel();
    t_cnt_mode();
    t_alt_lo();
    t_split_off();
    t_split_on();
    t_switch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule